// File: doc/BRIEF.md
# Zero-turnaround synchronous SRAM

This block is a synthesizable model of a synchronous static RAM that can alternate reads and writes on every clock with no idle cycle on its data bus. Address, selects, byte enables and the read/write choice are captured on the rising clock edge. Write data trails its address by a fixed number of active edges (late write). A read that arrives while an earlier write is still waiting for its data therefore has to be answered from that pending write. The memory array is written in a form that maps onto block RAM.

A strap chooses between a pipelined mode, which adds an output register, and a flow-through mode, which has no output register. A two-bit burst counter runs up to three extra beats after a loaded access. It steps either linearly or in interleaved order. A clock enable freezes the whole block. An output enable gates the data drive without waiting for a clock edge. The bidirectional data bus is split into a data input, a data output and a drive-enable flag.

Top module: `lw_sram`

## Requirements
- R1: Synchronous active-high `rst` clears all access state: `dq_oe` is low after reset, and a burst-continue cycle right after reset does nothing.
- R2: While `cke_n` is high on an edge, nothing advances: no access is loaded, no memory is written, and `dout`/`dq_oe` hold the values they had before that edge.
- R3: The block is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A load cycle (`cont_burst`=0) that is not selected is a deselect: no read data is driven and no write takes place. A burst-continue after a deselect also does nothing.
- R4: A selected load cycle starts a read when `wr_n`=1 and a write when `wr_n`=0, at `addr`. On continue cycles (`cont_burst`=1) the selects and `wr_n` are ignored and the loaded operation type is kept.
- R5: `be_n` is active low and sampled on every beat. Bit b covers `din`/`dout` bits [9b+8:9b]. A write beat with all `be_n` high changes no memory.
- R6: With `pipe_mode`=1, read data and `dq_oe`=1 appear after the second active edge following the read beat, for one active cycle.
- R7: With `pipe_mode`=0, read data and `dq_oe`=1 appear after the first active edge following the read beat.
- R8: A load sets the burst start to `addr[1:0]`, and the upper address bits are held for the burst. Beat n (n = 0..3, modulo 4) uses offset start+n mod 4 when `ilv_order`=0, and start XOR n when `ilv_order`=1.
- R9: `out_en_n`=1 forces `dq_oe` low at once, with no clock edge, and leaves `dout` unchanged.
- R10: Write data for a beat is taken from `din` on the second active edge after that beat (`pipe_mode`=1), or on the first (`pipe_mode`=0).
- R11: A read returns the memory content produced by every write beat issued before it, including writes still waiting for data, merged byte by byte. This holds for back-to-back read-write-read sequences with no idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cke_n | input | 1 | Clock enable, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| cont_burst | input | 1 | 1 = advance burst, 0 = load new access |
| wr_n | input | 1 | 0 = write, 1 = read on a load cycle |
| be_n | input | BYTES | Byte write enables, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data (late) |
| pipe_mode | input | 1 | Strap: 1 = pipelined, 0 = flow-through |
| ilv_order | input | 1 | Strap: 1 = interleaved, 0 = linear burst |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dout | output | DATA_W | Read data |
| dq_oe | output | 1 | Data drive enable |

## Verification
Assertions check on every clock the relations that span one edge. A frozen edge leaves the output data unchanged. A deselected load produces no read, and a selected read load always produces one. A load restarts the beat counter. The pipelined stage lags the first read stage by exactly one edge. Flow-through write scheduling trails the issued beat by one edge. Only the bench scenarios can show data correctness: forwarding from pending writes across both late-write distances, byte merging and write aborts, the burst address order in both modes, and the asynchronous effect of the output enable. The bench compares each of these against a reference memory that is updated at issue time.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Offset of a burst beat within the 4-word group
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input logic       interleave);
    return interleave ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/lw_burst_ctl.sv
module lw_burst_ctl
  import lw_sram_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cke_n,
  input  logic          sel,
  input  logic          cont,
  input  logic          wr_n,
  input  logic          ilv,
  input  logic [AW-1:0] addr,
  input  logic [NB-1:0] be_n,
  output op_e           op_kind,
  output logic [AW-1:0] op_addr,
  output logic [NB-1:0] op_be_n
);

  logic          act_q;
  op_e           kind_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [1:0]    nxt_cnt;

  assign nxt_cnt = cnt_q + 2'd1;

  always_comb begin
    op_kind = OP_NONE;
    op_addr = addr;
    op_be_n = be_n;
    if (!cont) begin
      if (sel) op_kind = wr_n ? OP_RD : OP_WR;
    end else if (act_q) begin
      op_kind = kind_q;
      op_addr = {base_q[AW-1:2], beat_offset(base_q[1:0], nxt_cnt, ilv)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      kind_q <= OP_NONE;
      base_q <= '0;
      cnt_q  <= 2'd0;
    end else if (!cke_n) begin
      if (!cont) begin
        act_q  <= sel;
        kind_q <= sel ? (wr_n ? OP_RD : OP_WR) : OP_NONE;
        base_q <= addr;
        cnt_q  <= 2'd0;
      end else if (act_q) begin
        cnt_q <= nxt_cnt;
      end
    end
  end

  AST_LOAD_RESTARTS_BEAT: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !cont) |=> (cnt_q == 2'd0)); // R8

  AST_DESELECT_IDLES_BURST: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !cont && !sel) |=> !act_q); // R3

endmodule

// File: rtl/lw_wr_delay.sv
module lw_wr_delay #(
  parameter int AW = 8,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cke_n,
  input  logic          pipe_mode,
  input  logic          in_v,
  input  logic [AW-1:0] in_addr,
  input  logic [NB-1:0] in_be_n,
  output logic          due_v,
  output logic [AW-1:0] due_addr,
  output logic [NB-1:0] due_be_n
);

  localparam int STAGES = 2;
  localparam int LAST   = STAGES - 1;

  logic [STAGES-1:0] v_q;
  logic [AW-1:0]     a_q [STAGES];
  logic [NB-1:0]     b_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
    end else if (!cke_n) begin
      v_q[0] <= in_v;
      for (int s = 1; s < STAGES; s++) v_q[s] <= v_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!cke_n) begin
      a_q[0] <= in_addr;
      b_q[0] <= in_be_n;
      for (int s = 1; s < STAGES; s++) begin
        a_q[s] <= a_q[s-1];
        b_q[s] <= b_q[s-1];
      end
    end
  end

  assign due_v    = pipe_mode ? v_q[LAST] : v_q[0];
  assign due_addr = pipe_mode ? a_q[LAST] : a_q[0];
  assign due_be_n = pipe_mode ? b_q[LAST] : b_q[0];

  AST_FLOW_WRITE_DUE_NEXT: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !pipe_mode) |=> (due_v == $past(in_v))); // R10

endmodule

// File: rtl/lw_mem_core.sv
module lw_mem_core #(
  parameter int AW = 8,
  parameter int NB = 2,
  parameter int BW = 9
) (
  input  logic             clk,
  input  logic             cke_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [NB-1:0]    wbe_n,
  input  logic [NB*BW-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [NB*BW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;
  localparam int DW    = NB * BW;

  logic [DW-1:0] mem [DEPTH];

  // byte-enabled write port
  always_ff @(posedge clk) begin
    if (!cke_n && we) begin
      for (int b = 0; b < NB; b++) begin
        if (!wbe_n[b]) mem[waddr][b*BW +: BW] <= wdata[b*BW +: BW];
      end
    end
  end

  // read-first registered read port
  always_ff @(posedge clk) begin
    if (!cke_n) rdata <= mem[raddr];
  end

endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 9,
  parameter int BYTES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cke_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    cont_burst,
  input  logic                    wr_n,
  input  logic [BYTES-1:0]        be_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*BYTE_W-1:0] din,
  input  logic                    pipe_mode,
  input  logic                    ilv_order,
  input  logic                    out_en_n,
  output logic [BYTES*BYTE_W-1:0] dout,
  output logic                    dq_oe
);

  localparam int DATA_W = BYTES * BYTE_W;

  logic              sel;
  op_e               op_kind;
  logic [ADDR_W-1:0] op_addr;
  logic [BYTES-1:0]  op_be_n;
  logic              due_v;
  logic [ADDR_W-1:0] due_addr;
  logic [BYTES-1:0]  due_be_n;
  logic [DATA_W-1:0] ram_q;

  logic              rd_v1, rd_v2;
  logic [ADDR_W-1:0] rd_a1;
  logic [BYTES-1:0]  fwd1_mask, fwd2_mask;
  logic [DATA_W-1:0] fwd1_data;
  logic [DATA_W-1:0] rd1_data, stg2_in, out_q;
  logic              is_rd;

  assign sel   = !sel_a_n && sel_b && !sel_c_n;
  assign is_rd = (op_kind == OP_RD);

  lw_burst_ctl #(.AW(ADDR_W), .NB(BYTES)) u_burst (
    .clk     (clk),
    .rst     (rst),
    .cke_n   (cke_n),
    .sel     (sel),
    .cont    (cont_burst),
    .wr_n    (wr_n),
    .ilv     (ilv_order),
    .addr    (addr),
    .be_n    (be_n),
    .op_kind (op_kind),
    .op_addr (op_addr),
    .op_be_n (op_be_n)
  );

  lw_wr_delay #(.AW(ADDR_W), .NB(BYTES)) u_wdly (
    .clk       (clk),
    .rst       (rst),
    .cke_n     (cke_n),
    .pipe_mode (pipe_mode),
    .in_v      (op_kind == OP_WR),
    .in_addr   (op_addr),
    .in_be_n   (op_be_n),
    .due_v     (due_v),
    .due_addr  (due_addr),
    .due_be_n  (due_be_n)
  );

  lw_mem_core #(.AW(ADDR_W), .NB(BYTES), .BW(BYTE_W)) u_mem (
    .clk   (clk),
    .cke_n (cke_n),
    .we    (due_v),
    .waddr (due_addr),
    .wbe_n (due_be_n),
    .wdata (din),
    .raddr (op_addr),
    .rdata (ram_q)
  );

  // first read stage: capture forwarding from the write whose data lands now
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v1     <= 1'b0;
      fwd1_mask <= '0;
    end else if (!cke_n) begin
      rd_v1     <= is_rd;
      fwd1_mask <= (due_v && is_rd && due_addr == op_addr) ? ~due_be_n : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!cke_n) begin
      rd_a1     <= op_addr;
      fwd1_data <= din;
    end
  end

  // second stage sees write data that lands one edge after the read
  assign fwd2_mask = (due_v && rd_v1 && due_addr == rd_a1) ? ~due_be_n : '0;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign rd1_data[b*BYTE_W +: BYTE_W] = fwd1_mask[b] ? fwd1_data[b*BYTE_W +: BYTE_W]
                                                       : ram_q[b*BYTE_W +: BYTE_W];
    assign stg2_in[b*BYTE_W +: BYTE_W]  = fwd2_mask[b] ? din[b*BYTE_W +: BYTE_W]
                                                       : rd1_data[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_v2 <= 1'b0;
    else if (!cke_n) rd_v2 <= rd_v1;
  end

  always_ff @(posedge clk) begin
    if (!cke_n) out_q <= stg2_in;
  end

  assign dout  = pipe_mode ? out_q : rd1_data;
  assign dq_oe = !out_en_n && (pipe_mode ? rd_v2 : rd_v1);

  AST_FROZEN_DOUT_STABLE: assert property (@(posedge clk) disable iff (rst)
    cke_n |=> $stable(dout)); // R2

  AST_DESELECT_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !cont_burst && !(!sel_a_n && sel_b && !sel_c_n)) |=> !rd_v1); // R3

  AST_READ_LOAD_STARTS: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !cont_burst && !sel_a_n && sel_b && !sel_c_n && wr_n) |=> rd_v1); // R4

  AST_PIPE_STAGE_LAG: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && pipe_mode) |=> (rd_v2 == $past(rd_v1))); // R6

endmodule

// File: tb/tb_lw_sram.sv
`timescale 1ns/1ps
module tb_lw_sram;

  localparam int AW = 8;
  localparam int DW = 18;
  localparam int NV = 30;
  localparam int SZ = 64;

  // vector: [30] freeze, [29:28] kind (0 deselect,1 read,2 write,3 continue),
  //         [27:20] addr, [19:18] be_n, [17:0] write data
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 2'd2, 8'h10, 2'b00, 18'h01111},
    {1'b0, 2'd2, 8'h11, 2'b00, 18'h02222},
    {1'b0, 2'd2, 8'h20, 2'b00, 18'h05555},
    {1'b0, 2'd1, 8'h10, 2'b00, 18'h00000},
    {1'b0, 2'd1, 8'h11, 2'b00, 18'h00000},
    {1'b0, 2'd2, 8'h10, 2'b10, 18'h0ABCD},
    {1'b0, 2'd1, 8'h10, 2'b00, 18'h00000},
    {1'b0, 2'd2, 8'h20, 2'b11, 18'h3FFFF},
    {1'b0, 2'd1, 8'h20, 2'b00, 18'h00000},
    {1'b0, 2'd2, 8'h31, 2'b00, 18'h00001},
    {1'b0, 2'd3, 8'h00, 2'b00, 18'h00002},
    {1'b0, 2'd3, 8'h00, 2'b00, 18'h00003},
    {1'b0, 2'd3, 8'h00, 2'b00, 18'h00004},
    {1'b1, 2'd2, 8'h31, 2'b00, 18'h3F0F0},
    {1'b0, 2'd1, 8'h31, 2'b00, 18'h00000},
    {1'b0, 2'd3, 8'h00, 2'b00, 18'h00000},
    {1'b1, 2'd2, 8'h32, 2'b00, 18'h12121},
    {1'b0, 2'd3, 8'h00, 2'b00, 18'h00000},
    {1'b0, 2'd3, 8'h00, 2'b00, 18'h00000},
    {1'b0, 2'd0, 8'h33, 2'b00, 18'h2D2D2},
    {1'b0, 2'd3, 8'h33, 2'b00, 18'h1E1E1},
    {1'b0, 2'd1, 8'h10, 2'b00, 18'h00000},
    {1'b0, 2'd2, 8'h12, 2'b00, 18'h12345},
    {1'b0, 2'd1, 8'h12, 2'b00, 18'h00000},
    {1'b0, 2'd2, 8'h12, 2'b01, 18'h2AAAA},
    {1'b0, 2'd1, 8'h12, 2'b00, 18'h00000},
    {1'b0, 2'd1, 8'h11, 2'b00, 18'h00000},
    {1'b1, 2'd1, 8'h11, 2'b00, 18'h00000},
    {1'b0, 2'd2, 8'h11, 2'b00, 18'h00777},
    {1'b0, 2'd1, 8'h11, 2'b00, 18'h00000}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cke_n = 1'b0;
  logic          sel_a_n = 1'b1, sel_b = 1'b1, sel_c_n = 1'b0;
  logic          cont_burst = 1'b0, wr_n = 1'b1;
  logic [1:0]    be_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          pipe_mode = 1'b1, ilv_order = 1'b0, out_en_n = 1'b0;
  logic [DW-1:0] dout;
  logic          dq_oe;

  int n_chk = 0;
  int n_bad = 0;

  logic [DW-1:0] ref_mem [256];
  logic          expv [SZ];
  logic [DW-1:0] expd [SZ];
  logic          wv [SZ];
  logic [DW-1:0] wd [SZ];
  logic          m_act, m_wr;
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;

  always #2.5 clk = ~clk;

  lw_sram dut (
    .clk(clk), .rst(rst), .cke_n(cke_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .cont_burst(cont_burst), .wr_n(wr_n), .be_n(be_n),
    .addr(addr), .din(din), .pipe_mode(pipe_mode), .ilv_order(ilv_order),
    .out_en_n(out_en_n), .dout(dout), .dq_oe(dq_oe)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic idle_inputs();
    cke_n = 1'b0; cont_burst = 1'b0; sel_a_n = 1'b1; sel_b = 1'b1; sel_c_n = 1'b0;
    wr_n = 1'b1; be_n = 2'b11; addr = '0; din = '0; out_en_n = 1'b0;
  endtask

  task automatic do_reset(input logic pm, input logic il);
    @(negedge clk);
    idle_inputs();
    rst = 1'b1; pipe_mode = pm; ilv_order = il;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 drive after reset", {31'd0, dq_oe}, 32'd0);
  endtask

  task automatic run_table(input logic pm, input logic il);
    int   a;
    logic prev_oe;
    logic [DW-1:0] prev_do;
    string rtag;
    rtag = pm ? "R6 R4 R5 R8 R10 R11 read" : "R7 R4 R5 R8 R10 R11 read";
    do_reset(pm, il);
    for (int k = 0; k < SZ; k++) begin expv[k] = 1'b0; wv[k] = 1'b0; end
    m_act = 1'b0; m_wr = 1'b0; m_base = '0; m_cnt = 2'd0;
    a = 0;
    prev_oe = dq_oe; prev_do = dout;
    for (int i = 0; i < NV + 3; i++) begin
      logic [30:0]   v;
      logic [1:0]    c;
      logic          fz, iss;
      logic [AW-1:0] eff;
      v   = (i < NV) ? VEC[i] : 31'd0;
      fz  = v[30];
      c   = v[29:28];
      iss = 1'b0;
      eff = v[27:20];
      addr = v[27:20]; be_n = v[19:18]; sel_b = 1'b1; sel_c_n = 1'b0;
      din  = wv[a] ? wd[a] : 18'h15A5A;
      case (c)
        2'd0: begin cont_burst = 1'b0; sel_a_n = 1'b1; wr_n = 1'b0; end
        2'd1: begin cont_burst = 1'b0; sel_a_n = 1'b0; wr_n = 1'b1; end
        2'd2: begin cont_burst = 1'b0; sel_a_n = 1'b0; wr_n = 1'b0; end
        default: begin cont_burst = 1'b1; sel_a_n = 1'b1; wr_n = 1'b0; end
      endcase
      cke_n = fz;
      if (!fz) begin
        case (c)
          2'd0: m_act = 1'b0;
          2'd1, 2'd2: begin
            m_act = 1'b1; m_wr = (c == 2'd2); m_base = v[27:20]; m_cnt = 2'd0; iss = 1'b1;
          end
          default: if (m_act) begin
            m_cnt = m_cnt + 2'd1;
            eff = {m_base[AW-1:2], il ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
            iss = 1'b1;
          end
        endcase
        if (iss && !m_wr) begin
          expv[a + (pm ? 1 : 0)] = 1'b1;
          expd[a + (pm ? 1 : 0)] = ref_mem[eff];
        end else if (iss) begin
          wv[a + (pm ? 2 : 1)] = 1'b1;
          wd[a + (pm ? 2 : 1)] = v[17:0];
          for (int b = 0; b < 2; b++)
            if (!v[18+b]) ref_mem[eff][b*9 +: 9] = v[b*9 +: 9];
        end
      end
      @(posedge clk);
      @(negedge clk);
      if (fz) begin
        check("R2 frozen dq_oe", {31'd0, dq_oe}, {31'd0, prev_oe});
        check("R2 frozen dout", {14'd0, dout}, {14'd0, prev_do});
      end else begin
        if (expv[a]) begin
          check({rtag, " oe"}, {31'd0, dq_oe}, 32'd1);
          check({rtag, " data"}, {14'd0, dout}, {14'd0, expd[a]});
        end else begin
          check("R3 no drive", {31'd0, dq_oe}, 32'd0);
        end
        a++;
      end
      prev_oe = dq_oe; prev_do = dout;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: continue right after reset must not start anything
    do_reset(1'b1, 1'b0);
    cont_burst = 1'b1; sel_a_n = 1'b0; wr_n = 1'b1;
    @(posedge clk); @(negedge clk);
    idle_inputs();
    check("R1 continue after reset", {31'd0, dq_oe}, 32'd0);
    @(posedge clk); @(negedge clk);
    check("R1 continue after reset", {31'd0, dq_oe}, 32'd0);

    run_table(1'b1, 1'b0);
    run_table(1'b0, 1'b1);
    run_table(1'b1, 1'b1);
    run_table(1'b0, 1'b0);

    // R9: output enable gates the drive without a clock edge
    do_reset(1'b1, 1'b0);
    cont_burst = 1'b0; sel_a_n = 1'b0; wr_n = 1'b1; addr = 8'h10;
    @(posedge clk); @(negedge clk);
    idle_inputs();
    @(posedge clk); @(negedge clk);
    check("R6 read before gating", {31'd0, dq_oe}, 32'd1);
    out_en_n = 1'b1;
    #0.5;
    check("R9 oe forced low", {31'd0, dq_oe}, 32'd0);
    check("R9 data unchanged", {14'd0, dout}, {14'd0, ref_mem[8'h10]});
    out_en_n = 1'b0;
    #0.5;
    check("R9 oe restored", {31'd0, dq_oe}, 32'd1);

    finish_run();
  end

endmodule